// File: doc/BRIEF.md
# DMA Channel Address and Count Register File

This block stores the programming state of four DMA channels: for each one a 16-bit starting address, a 16-bit transfer count, a live current address and a live transfer position. Software reaches all of it through a single 8-bit port. The port offset picks the channel and chooses between the address register and the count register. One byte pointer, shared by every channel, decides whether an access touches the low byte or the high byte. The pointer toggles on every port access. A separate control unit can force the pointer back to the low byte.

The byte pointer is a two-state machine. In state `PTR_LOW` an access uses bits 7:0 and the transition `ADVANCE` moves it to `PTR_HIGH`. In state `PTR_HIGH` an access uses bits 15:8 and the transition `ADVANCE` returns it to `PTR_LOW`. The transition `FORCE_LOW` goes from either state to `PTR_LOW` and wins over `ADVANCE` in the same cycle. With no access and no clear, the machine stays where it is (`HOLD`).

Readback does not return the stored registers. An address read returns the current address moved by the position: forward, or backward when the channel's decrement flag is set. A count read returns the count still remaining. A transfer engine sees each channel's current address and position on flat output buses. It writes new positions through its own per-channel enables. The `SHIFT` parameter adapts the block to a word-wide instance: offsets are divided by 2^SHIFT, and values are scaled by 2^SHIFT before a byte is extracted.

Top module: `dma_chan_regfile`

## Requirements
- R1: After reset every channel's current address, position, start address and count are zero, and the byte pointer is in `PTR_LOW`.
- R2: Every port access (`bus_sel`=1, read or write) advances the byte pointer to the other state. The pointer state before the access selects the byte: `PTR_LOW` selects bits 7:0 and `PTR_HIGH` selects bits 15:8.
- R3: `ptr_clr`=1 puts the pointer in `PTR_LOW` at the next edge, even when a port access happens in the same cycle.
- R4: A write in `PTR_LOW` replaces bits 7:0 of the selected stored register and keeps bits 15:8. A write in `PTR_HIGH` replaces bits 15:8 and keeps bits 7:0.
- R5: A write in `PTR_HIGH` to either register of a channel loads that channel's current address with its start address (including the byte just written) times 2^SHIFT, and clears its position to zero.
- R6: A write in `PTR_LOW` leaves every current address and every position unchanged.
- R7: An address read returns a byte of (current address + position) when the channel's `dec_mode` bit is 0, and of (current address − position) when it is 1, modulo 2^(16+SHIFT).
- R8: A count read returns a byte of (count × 2^SHIFT − position), modulo 2^(16+SHIFT).
- R9: When `pos_we[c]`=1, channel c's position takes the value of its lane of `pos_in` at the next edge. No other channel's position changes.
- R10: When a `PTR_HIGH` write to channel c and `pos_we[c]` arrive in the same cycle, the write wins and the position becomes zero.
- R11: Port offset decode: iport = `bus_off` >> SHIFT. Bit 0 of iport selects address (0) or count (1), and bits 2:1 select the channel. `bus_rdata` is zero when no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Port access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_off | input | 3+SHIFT | Port offset |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, combinational during a read |
| ptr_clr | input | 1 | Force the byte pointer to the low state |
| dec_mode | input | 4 | Per-channel decrement flag for address readback |
| pos_we | input | 4 | Per-channel position load enable |
| pos_in | input | 4×(16+SHIFT) | New positions, one lane per channel |
| cur_addr | output | 4×(16+SHIFT) | Current address per channel |
| cur_pos | output | 4×(16+SHIFT) | Transfer position per channel |

## Verification
The register function is exercised with writes in both pointer states, addressed to different channels and to both register kinds. Each write is followed by a look at the live outputs, which separates a low-byte write (no reload) from a high-byte write (reload and position clear). Readback is tried with zero and non-zero positions and with both directions, which separates plain register readback from computed readback and increment from decrement. The pointer is tested by pairing a clear with an access in the same cycle. Position loads are tested both alone and in collision with a high-byte write, which shows the priority rules and shows that each channel's enable is independent.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
    typedef enum logic {
        PTR_LOW  = 1'b0,
        PTR_HIGH = 1'b1
    } ptr_e;

    typedef enum logic {
        REG_ADDR  = 1'b0,
        REG_COUNT = 1'b1
    } reg_e;
endpackage

// File: rtl/dcr_byte_ptr.sv
module dcr_byte_ptr
    import dcr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic access,
    input  logic clr,
    output ptr_e state,
    output logic hi_sel
);
    ptr_e state_q, state_d;

    // next state: FORCE_LOW beats ADVANCE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PTR_LOW: begin
                if (clr)         state_d = PTR_LOW;
                else if (access) state_d = PTR_HIGH;
            end
            PTR_HIGH: begin
                if (clr || access) state_d = PTR_LOW;
            end
            default: state_d = PTR_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PTR_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state  = state_q;
        hi_sel = (state_q == PTR_HIGH);
    end
endmodule

// File: rtl/dcr_channel.sv
module dcr_channel
    import dcr_pkg::*;
#(
    parameter int SHIFT = 0,
    parameter int VAL_W = 16 + SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  reg_e             wr_reg,
    input  logic [7:0]       wdata,
    input  logic             pos_we,
    input  logic [VAL_W-1:0] pos_in,
    input  logic             dec,
    output logic [VAL_W-1:0] cur_addr,
    output logic [VAL_W-1:0] pos,
    output logic [VAL_W-1:0] addr_rd,
    output logic [VAL_W-1:0] cnt_rd
);
    logic [15:0] start_q, count_q;
    logic [15:0] start_next;

    // start address as it stands after this cycle's high-byte write
    always_comb begin
        start_next = start_q;
        if (wr_hi && wr_reg == REG_ADDR) start_next = {wdata, start_q[7:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q  <= '0;
            count_q  <= '0;
            cur_addr <= '0;
            pos      <= '0;
        end else begin
            if (wr_lo) begin
                if (wr_reg == REG_ADDR) start_q[7:0] <= wdata;
                else                    count_q[7:0] <= wdata;
            end
            if (wr_hi) begin
                if (wr_reg == REG_ADDR) start_q[15:8] <= wdata;
                else                    count_q[15:8] <= wdata;
                cur_addr <= VAL_W'(start_next) << SHIFT;
                pos      <= '0;
            end else if (pos_we) begin
                pos <= pos_in;
            end
        end
    end

    always_comb begin
        addr_rd = dec ? (cur_addr - pos) : (cur_addr + pos);
        cnt_rd  = (VAL_W'(count_q) << SHIFT) - pos;
    end
endmodule

// File: rtl/dcr_readmux.sv
module dcr_readmux
    import dcr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int SHIFT  = 0,
    parameter int VAL_W  = 16 + SHIFT,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic [NUM_CH*VAL_W-1:0] addr_vals,
    input  logic [NUM_CH*VAL_W-1:0] cnt_vals,
    input  logic [CH_W-1:0]         ch,
    input  reg_e                    reg_sel,
    input  logic                    hi,
    input  logic                    en,
    output logic [7:0]              rbyte
);
    logic [VAL_W-1:0] val, shifted;

    always_comb begin
        val     = (reg_sel == REG_COUNT) ? cnt_vals[ch*VAL_W +: VAL_W]
                                         : addr_vals[ch*VAL_W +: VAL_W];
        shifted = val >> (SHIFT + (hi ? 8 : 0));
        rbyte   = en ? shifted[7:0] : 8'h00;
    end
endmodule

// File: rtl/dma_chan_regfile.sv
module dma_chan_regfile
    import dcr_pkg::*;
#(
    parameter  int NUM_CH = 4,
    parameter  int SHIFT  = 0,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int OFF_W  = CH_W + 1 + SHIFT,
    localparam int VAL_W  = 16 + SHIFT
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_sel,
    input  logic                    bus_wr,
    input  logic [OFF_W-1:0]        bus_off,
    input  logic [7:0]              bus_wdata,
    output logic [7:0]              bus_rdata,
    input  logic                    ptr_clr,
    input  logic [NUM_CH-1:0]       dec_mode,
    input  logic [NUM_CH-1:0]       pos_we,
    input  logic [NUM_CH*VAL_W-1:0] pos_in,
    output logic [NUM_CH*VAL_W-1:0] cur_addr,
    output logic [NUM_CH*VAL_W-1:0] cur_pos
);
    ptr_e                    ptr_state;
    logic                    ptr_hi;
    logic [CH_W:0]           iport;
    logic [CH_W-1:0]         sel_ch;
    reg_e                    sel_reg;
    logic                    acc_wr, lo_wr_any;
    logic [NUM_CH-1:0]       hi_wr, lo_wr;
    logic [NUM_CH*VAL_W-1:0] addr_vals, cnt_vals;

    always_comb begin
        iport     = bus_off[OFF_W-1:SHIFT];
        sel_ch    = iport[CH_W:1];
        sel_reg   = reg_e'(iport[0]);
        acc_wr    = bus_sel && bus_wr;
        lo_wr_any = acc_wr && (ptr_state == PTR_LOW);
    end

    dcr_byte_ptr u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .access (bus_sel),
        .clr    (ptr_clr),
        .state  (ptr_state),
        .hi_sel (ptr_hi)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_comb begin
            lo_wr[c] = lo_wr_any && (sel_ch == CH_W'(c));
            hi_wr[c] = acc_wr && ptr_hi && (sel_ch == CH_W'(c));
        end

        dcr_channel #(.SHIFT(SHIFT), .VAL_W(VAL_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_lo    (lo_wr[c]),
            .wr_hi    (hi_wr[c]),
            .wr_reg   (sel_reg),
            .wdata    (bus_wdata),
            .pos_we   (pos_we[c]),
            .pos_in   (pos_in[c*VAL_W +: VAL_W]),
            .dec      (dec_mode[c]),
            .cur_addr (cur_addr[c*VAL_W +: VAL_W]),
            .pos      (cur_pos[c*VAL_W +: VAL_W]),
            .addr_rd  (addr_vals[c*VAL_W +: VAL_W]),
            .cnt_rd   (cnt_vals[c*VAL_W +: VAL_W])
        );
    end

    dcr_readmux #(.NUM_CH(NUM_CH), .SHIFT(SHIFT), .VAL_W(VAL_W), .CH_W(CH_W)) u_rmux (
        .addr_vals (addr_vals),
        .cnt_vals  (cnt_vals),
        .ch        (sel_ch),
        .reg_sel   (sel_reg),
        .hi        (ptr_hi),
        .en        (bus_sel && !bus_wr),
        .rbyte     (bus_rdata)
    );
endmodule

// File: rtl/dcr_checker.sv
module dcr_checker #(
    parameter int NUM_CH = 4,
    parameter int VAL_W  = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_sel,
    input logic                    ptr_clr,
    input logic                    ptr_hi,
    input logic                    lo_wr_any,
    input logic [NUM_CH-1:0]       hi_wr,
    input logic [NUM_CH-1:0]       pos_we,
    input logic [NUM_CH*VAL_W-1:0] pos_in,
    input logic [NUM_CH*VAL_W-1:0] cur_addr,
    input logic [NUM_CH*VAL_W-1:0] cur_pos
);
    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !ptr_clr) |=> (ptr_hi != $past(ptr_hi))); // R2

    AST_PTR_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_clr |=> !ptr_hi); // R3

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_sel && !ptr_clr) |=> $stable(ptr_hi)); // R2

    AST_LOW_WRITE_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr_any && pos_we == '0) |=> ($stable(cur_addr) && $stable(cur_pos))); // R6

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ast
        AST_HIGH_WRITE_CLEARS_POS: assert property (@(posedge clk) disable iff (!rst_n)
            hi_wr[c] |=> (cur_pos[c*VAL_W +: VAL_W] == '0)); // R10

        AST_POS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (pos_we[c] && !hi_wr[c]) |=>
                (cur_pos[c*VAL_W +: VAL_W] == $past(pos_in[c*VAL_W +: VAL_W]))); // R9
    end
endmodule

bind dma_chan_regfile dcr_checker #(.NUM_CH(NUM_CH), .VAL_W(VAL_W)) u_dcr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .ptr_clr   (ptr_clr),
    .ptr_hi    (ptr_hi),
    .lo_wr_any (lo_wr_any),
    .hi_wr     (hi_wr),
    .pos_we    (pos_we),
    .pos_in    (pos_in),
    .cur_addr  (cur_addr),
    .cur_pos   (cur_pos)
);

// File: tb/tb_dma_chan_regfile.sv
`timescale 1ns/1ps
module tb_dma_chan_regfile;
    localparam int NUM_CH = 4;
    localparam int SHIFT  = 0;
    localparam int VAL_W  = 16 + SHIFT;
    localparam int OFF_W  = 3 + SHIFT;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    bus_sel = 1'b0, bus_wr = 1'b0, ptr_clr = 1'b0;
    logic [OFF_W-1:0]        bus_off = '0;
    logic [7:0]              bus_wdata = '0, bus_rdata;
    logic [NUM_CH-1:0]       dec_mode = '0, pos_we = '0;
    logic [NUM_CH*VAL_W-1:0] pos_in = '0, cur_addr, cur_pos;

    int vectors = 0, miscompares = 0;
    bit finished = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    // requirement-level model
    logic [15:0]      m_start[NUM_CH], m_count[NUM_CH];
    logic [VAL_W-1:0] m_cur[NUM_CH], m_pos[NUM_CH];
    logic             m_ptr;

    always #2 clk = ~clk;

    dma_chan_regfile #(.NUM_CH(NUM_CH), .SHIFT(SHIFT)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_off(bus_off), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ptr_clr(ptr_clr), .dec_mode(dec_mode), .pos_we(pos_we),
        .pos_in(pos_in), .cur_addr(cur_addr), .cur_pos(cur_pos)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_byte(input logic [OFF_W-1:0] off);
        logic [2:0]       ip;
        int               ch;
        logic [VAL_W-1:0] v;
        ip = 3'(off >> SHIFT);
        ch = int'(ip[2:1]);
        if (ip[0]) v = (VAL_W'(m_count[ch]) << SHIFT) - m_pos[ch];
        else       v = dec_mode[ch] ? m_cur[ch] - m_pos[ch] : m_cur[ch] + m_pos[ch];
        v = v >> (SHIFT + (m_ptr ? 8 : 0));
        return v[7:0];
    endfunction

    // driver: one bus cycle, pushes expected read bytes, updates model
    task automatic bus_cycle(input string tag, input logic s, input logic w,
                             input logic [OFF_W-1:0] off, input logic [7:0] d,
                             input logic clr, input logic [NUM_CH-1:0] pwe,
                             input logic [VAL_W-1:0] pval);
        logic [2:0] ip;
        int         ch;
        @(posedge clk); #1;
        bus_sel = s; bus_wr = w; bus_off = off; bus_wdata = d;
        ptr_clr = clr; pos_we = pwe; pos_in = {NUM_CH{pval}};
        if (s && !w) begin
            exp_q.push_back(model_byte(off));
            tag_q.push_back(tag);
        end
        @(posedge clk);
        ip = 3'(off >> SHIFT);
        ch = int'(ip[2:1]);
        for (int c = 0; c < NUM_CH; c++) if (pwe[c]) m_pos[c] = pval;
        if (s && w) begin
            if (!m_ptr) begin
                if (ip[0]) m_count[ch][7:0] = d; else m_start[ch][7:0] = d;
            end else begin
                if (ip[0]) m_count[ch][15:8] = d; else m_start[ch][15:8] = d;
                m_cur[ch] = VAL_W'(m_start[ch]) << SHIFT;
                m_pos[ch] = '0;
            end
        end
        if (clr) m_ptr = 1'b0; else if (s) m_ptr = ~m_ptr;
        #1;
        bus_sel = 0; bus_wr = 0; ptr_clr = 0; pos_we = '0;
    endtask

    task automatic wr(input string tag, input logic [OFF_W-1:0] off, input logic [7:0] d);
        bus_cycle(tag, 1, 1, off, d, 0, '0, '0);
    endtask
    task automatic rd(input string tag, input logic [OFF_W-1:0] off);
        bus_cycle(tag, 1, 0, off, 8'h00, 0, '0, '0);
    endtask
    task automatic clr_ptr();
        bus_cycle("R3", 0, 0, '0, 8'h00, 1, '0, '0);
    endtask

    // monitor: compares read bytes between edges
    always @(negedge clk) begin
        if (bus_sel && !bus_wr) begin
            if (exp_q.size() == 0) chk("R11 unexpected read", 32'(bus_rdata), 32'hFFFF_FFFF);
            else chk(tag_q.pop_front(), 32'(bus_rdata), 32'(exp_q.pop_front()));
        end else if (rst_n && !bus_sel) begin
            if (bus_rdata !== 8'h00) chk("R11 idle rdata", 32'(bus_rdata), 32'h0);
        end
    end

    function automatic logic [VAL_W-1:0] lane(input logic [NUM_CH*VAL_W-1:0] b, input int c);
        return b[c*VAL_W +: VAL_W];
    endfunction

    initial begin
        #(4 * 200000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NUM_CH; c++) begin
            m_start[c] = '0; m_count[c] = '0; m_cur[c] = '0; m_pos[c] = '0;
        end
        m_ptr = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        for (int c = 0; c < NUM_CH; c++) begin
            chk("R1 cur_addr", 32'(lane(cur_addr, c)), 32'h0);
            chk("R1 cur_pos",  32'(lane(cur_pos, c)),  32'h0);
        end
        rd("R1 low byte after reset", 3'd0);
        rd("R2 high byte second access", 3'd0);

        // channel 1 address and count
        clr_ptr();
        wr("R6", 3'd2, 8'h34);
        chk("R6 low write no reload", 32'(lane(cur_addr, 1)), 32'h0);
        wr("R5", 3'd2, 8'h12);
        chk("R5 reload addr", 32'(lane(cur_addr, 1)), 32'h1234);
        chk("R5 pos cleared", 32'(lane(cur_pos, 1)), 32'h0);
        wr("R4", 3'd3, 8'h10);
        wr("R4", 3'd3, 8'h00);
        chk("R5 count write reloads addr", 32'(lane(cur_addr, 1)), 32'h1234);

        bus_cycle("R9", 0, 0, '0, 8'h00, 0, 4'b0010, 16'd5);
        chk("R9 pos load", 32'(lane(cur_pos, 1)), 32'd5);
        chk("R9 other channel", 32'(lane(cur_pos, 0)), 32'd0);
        rd("R7 inc low", 3'd2);
        rd("R7 inc high", 3'd2);
        rd("R8 count low", 3'd3);
        rd("R8 count high", 3'd3);
        dec_mode = 4'b0010;
        rd("R7 dec low", 3'd2);
        rd("R7 dec high", 3'd2);
        dec_mode = 4'b0000;

        clr_ptr();
        wr("R6", 3'd2, 8'hFF);
        chk("R6 addr kept", 32'(lane(cur_addr, 1)), 32'h1234);
        chk("R6 pos kept",  32'(lane(cur_pos, 1)),  32'd5);
        bus_cycle("R10", 1, 1, 3'd2, 8'h40, 0, 4'b0010, 16'd9);
        chk("R10 high write beats pos load", 32'(lane(cur_pos, 1)), 32'd0);
        chk("R4 low byte kept on high write", 32'(lane(cur_addr, 1)), 32'h40FF);

        // pointer clear against a concurrent access
        clr_ptr();
        rd("R3 low", 3'd2);
        bus_cycle("R3 read with clear", 1, 0, 3'd2, 8'h00, 1, '0, '0);
        rd("R3 low after clear", 3'd2);
        chk("R3 addr unchanged", 32'(lane(cur_addr, 1)), 32'h40FF);

        // decode of channels 2 and 3
        clr_ptr();
        wr("R11", 3'd7, 8'h22);
        wr("R11", 3'd7, 8'h01);
        wr("R11", 3'd4, 8'hAB);
        wr("R11", 3'd4, 8'hCD);
        chk("R11 ch2 addr", 32'(lane(cur_addr, 2)), 32'hCDAB);
        chk("R11 ch3 addr", 32'(lane(cur_addr, 3)), 32'h0);
        chk("R11 ch1 untouched", 32'(lane(cur_addr, 1)), 32'h40FF);
        bus_cycle("R9", 0, 0, '0, 8'h00, 0, 4'b1100, 16'h0010);
        chk("R9 ch2 pos", 32'(lane(cur_pos, 2)), 32'h10);
        chk("R9 ch1 pos kept", 32'(lane(cur_pos, 1)), 32'h0);
        rd("R8 ch3 count low", 3'd7);
        rd("R8 ch3 count high", 3'd7);
        rd("R7 ch2 addr low", 3'd4);
        rd("R7 ch2 addr high", 3'd4);
        wr("R4", 3'd4, 8'h01);
        wr("R4", 3'd4, 8'hEF);
        chk("R4 both bytes", 32'(lane(cur_addr, 2)), 32'hEF01);

        repeat (2) @(posedge clk);
        chk("R2 all reads consumed", 32'(exp_q.size()), 32'd0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule